// File: doc/BRIEF.md
# Bang-bang PLL proportional-integral loop filter

This block is the digital loop filter of a type-II phase-locked loop whose phase detector gives only one bit per reference cycle. A flip-flop that samples the reference against the divided clock reports whether the divided clock is late or early. On each reference strobe the filter moves an integral accumulator by a fixed integral step. It then adds or subtracts a fixed proportional step and saturates the sum into an 8-bit fine frequency word. That word also leaves the block as a 256-wide thermometer vector for the oscillator's tuning array.

A 7-bit coarse band word sits alongside the fine word. During acquisition, a fine word held at one end of its range for a programmable run of strobes moves the coarse band one step toward that end. The same event puts the integrator back to mid-scale, so that the fine loop can settle inside the new band. Once the lock input is raised, the coarse band stays frozen and only the fine loop keeps tracking.

Top module: `bbpll_loop_filter`

## Requirements
- R1: After reset the integrator and fine_code_o are 128, coarse_o equals the COARSE_INIT parameter, and fine_therm_o has its 128 lowest bits set.
- R2: On a clock edge with ref_tick_i low, fine_code_o, fine_therm_o and coarse_o keep their values.
- R3: On a clock edge with ref_tick_i high, the integrator adds KI when phase_late_i is 1 and subtracts KI when it is 0, saturating to 0..255.
- R4: On that same edge fine_code_o takes the new integrator value plus KP (late = 1) or minus KP (late = 0), saturated to 0..255.
- R5: Bit k of fine_therm_o is 1 exactly when k < fine_code_o, so its count of ones equals fine_code_o.
- R6: With lock_i low, SAT_CYCLES consecutive strobes whose new fine value is pinned at the same end (255 or 0) step coarse_o by +1 (at 255) or -1 (at 0) and set the integrator and fine_code_o to 128. A strobe that is not pinned, or that is pinned at the other end, starts the run count again.
- R7: coarse_o never leaves 0..127. A completed run that would push it past a limit leaves coarse_o and the fine loop unchanged, and the run count starts again.
- R8: While lock_i is high on a strobe, coarse_o does not change and the run count is cleared; the fine loop still updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_tick_i | input | 1 | One-cycle strobe per reference cycle |
| phase_late_i | input | 1 | Quantised phase error: 1 = divided clock late (raise frequency), 0 = early |
| lock_i | input | 1 | Freezes the coarse band when high |
| fine_code_o | output | 8 | Binary fine frequency word |
| fine_therm_o | output | 256 | Thermometer form of the fine word |
| coarse_o | output | 7 | Coarse frequency band word |

## Verification
On every cycle the assertions check several properties. The thermometer vector's count of ones matches the fine word. The coarse band moves by exactly one and never wraps. Any coarse move arrives with the fine word recentred, and the band holds while locked. A missing strobe leaves the fine word alone, and the integrator moves in the direction of the phase bit. Only the bench's scenarios can show the exact saturating arithmetic of the proportional and integral steps, the run length that triggers a band move, the run restarting after an interruption, and the clamping at band 0 and band 127. The bench compares all three outputs on every cycle against an arithmetic model through long late-only, early-only and pseudo-random phase streams.

// File: rtl/bbpll_lf_pkg.sv
package bbpll_lf_pkg;
  function automatic int clamp_int(int v, int lo, int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction
endpackage

// File: rtl/bbpll_pi_core.sv
module bbpll_pi_core #(
  parameter int FINE_W = 8,
  parameter int KP     = 4,
  parameter int KI     = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              late_i,
  input  logic              recentre_i,
  output logic [FINE_W-1:0] fine_n_o,
  output logic [FINE_W-1:0] fine_o
);
  import bbpll_lf_pkg::*;
  localparam int MAXV = (1 << FINE_W) - 1;
  localparam int MID  = 1 << (FINE_W - 1);

  logic [FINE_W-1:0] integ_q, integ_n;

  always_comb begin
    int si, sf;
    si = int'(integ_q) + (late_i ? KI : -KI);
    integ_n = FINE_W'(clamp_int(si, 0, MAXV));
    sf = int'(integ_n) + (late_i ? KP : -KP);
    fine_n_o = FINE_W'(clamp_int(sf, 0, MAXV));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      integ_q <= FINE_W'(MID);
      fine_o  <= FINE_W'(MID);
    end else if (tick_i) begin
      if (recentre_i) begin
        integ_q <= FINE_W'(MID);
        fine_o  <= FINE_W'(MID);
      end else begin
        integ_q <= integ_n;
        fine_o  <= fine_n_o;
      end
    end
  end

  assert_integ_up_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !recentre_i && late_i) |=> (integ_q >= $past(integ_q)));
  assert_integ_dn_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !recentre_i && !late_i) |=> (integ_q <= $past(integ_q)));
  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(fine_o));
endmodule

// File: rtl/bbpll_coarse_acq.sv
module bbpll_coarse_acq #(
  parameter int FINE_W      = 8,
  parameter int COARSE_W    = 7,
  parameter int SAT_CYCLES  = 16,
  parameter int COARSE_INIT = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                lock_i,
  input  logic [FINE_W-1:0]   fine_n_i,
  output logic [COARSE_W-1:0] coarse_o,
  output logic                recentre_o
);
  localparam int CW   = $clog2(SAT_CYCLES + 1);
  localparam int FMAX = (1 << FINE_W) - 1;
  localparam int CMAX = (1 << COARSE_W) - 1;

  logic [CW-1:0] cnt_q, run_n;
  logic          dir_q, pin_hi, pin_lo, pinned, full, can_move;

  always_comb begin
    pin_hi   = fine_n_i == FINE_W'(FMAX);
    pin_lo   = fine_n_i == '0;
    pinned   = pin_hi || pin_lo;
    run_n    = (cnt_q != '0 && dir_q == pin_hi) ? cnt_q + 1'b1 : CW'(1);
    full     = run_n == CW'(SAT_CYCLES);
    can_move = pin_hi ? (coarse_o != COARSE_W'(CMAX)) : (coarse_o != '0);
    recentre_o = tick_i && !lock_i && pinned && full && can_move;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      dir_q    <= 1'b0;
      coarse_o <= COARSE_W'(COARSE_INIT);
    end else if (tick_i) begin
      if (lock_i || !pinned) begin
        cnt_q <= '0;
      end else begin
        dir_q <= pin_hi;
        cnt_q <= full ? '0 : run_n;
        if (recentre_o) coarse_o <= pin_hi ? coarse_o + 1'b1 : coarse_o - 1'b1;
      end
    end
  end

  assert_lock_freeze_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> $stable(coarse_o));
  assert_coarse_unit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coarse_o != $past(coarse_o)) |->
      (int'(coarse_o) == int'($past(coarse_o)) + 1 || int'(coarse_o) == int'($past(coarse_o)) - 1));
endmodule

// File: rtl/bbpll_therm.sv
module bbpll_therm #(
  parameter int FINE_W = 8
) (
  input  logic [FINE_W-1:0]        fine_i,
  output logic [(1<<FINE_W)-1:0]   therm_o
);
  localparam int LEVELS = 1 << FINE_W;
  for (genvar k = 0; k < LEVELS; k++) begin : g_bit
    assign therm_o[k] = int'(fine_i) > k;
  end
endmodule

// File: rtl/bbpll_loop_filter.sv
module bbpll_loop_filter #(
  parameter int FINE_W      = 8,
  parameter int COARSE_W    = 7,
  parameter int KP          = 4,
  parameter int KI          = 1,
  parameter int SAT_CYCLES  = 16,
  parameter int COARSE_INIT = 64
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   ref_tick_i,
  input  logic                   phase_late_i,
  input  logic                   lock_i,
  output logic [FINE_W-1:0]      fine_code_o,
  output logic [(1<<FINE_W)-1:0] fine_therm_o,
  output logic [COARSE_W-1:0]    coarse_o
);
  localparam int MID = 1 << (FINE_W - 1);

  logic [FINE_W-1:0] fine_n;
  logic              recentre;

  bbpll_pi_core #(.FINE_W(FINE_W), .KP(KP), .KI(KI)) u_core (
    .clk_i, .rst_ni, .tick_i(ref_tick_i), .late_i(phase_late_i),
    .recentre_i(recentre), .fine_n_o(fine_n), .fine_o(fine_code_o)
  );

  bbpll_coarse_acq #(.FINE_W(FINE_W), .COARSE_W(COARSE_W),
                     .SAT_CYCLES(SAT_CYCLES), .COARSE_INIT(COARSE_INIT)) u_acq (
    .clk_i, .rst_ni, .tick_i(ref_tick_i), .lock_i, .fine_n_i(fine_n),
    .coarse_o, .recentre_o(recentre)
  );

  bbpll_therm #(.FINE_W(FINE_W)) u_therm (.fine_i(fine_code_o), .therm_o(fine_therm_o));

  assert_therm_count_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(fine_therm_o) == int'(fine_code_o));
  assert_step_recentres_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coarse_o != $past(coarse_o)) |-> (int'(fine_code_o) == MID));
endmodule

// File: tb/sim_bbpll_loop_filter.sv
module sim_bbpll_loop_filter;
  localparam int KP = 3, KI = 1, SAT = 4, CINIT = 64;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, late = 1'b0, lock = 1'b0;
  logic [7:0]   fine;
  logic [255:0] therm;
  logic [6:0]   coarse;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  int mi = 128, mf = 128, mc = CINIT, mcnt = 0;
  bit mdir = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  bbpll_loop_filter #(.KP(KP), .KI(KI), .SAT_CYCLES(SAT), .COARSE_INIT(CINIT)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ref_tick_i(tick), .phase_late_i(late), .lock_i(lock),
    .fine_code_o(fine), .fine_therm_o(therm), .coarse_o(coarse)
  );

  function automatic int clampv(int v);
    return v < 0 ? 0 : (v > 255 ? 255 : v);
  endfunction

  task automatic chk(string r, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic chk_all(string r);
    logic [255:0] ev;
    for (int k = 0; k < 256; k++) ev[k] = (k < mf);
    chk(r, int'(fine), mf);
    chk(r, int'(coarse), mc);
    if (therm != ev) begin
      n_chk++; n_fail++;
      $display("FAIL R5 therm ones actual=%0d expected=%0d", $countones(therm), mf);
    end else n_chk++;
  endtask

  // model of one clock edge, from the requirements
  task automatic model(bit t, bit l, bit lk);
    int e, ni, nf, c1;
    bit hi;
    if (!t) return;
    e  = l ? 1 : -1;
    ni = clampv(mi + e * KI);
    nf = clampv(ni + e * KP);
    if (lk || (nf != 0 && nf != 255)) mcnt = 0;
    else begin
      hi = (nf == 255);
      c1 = (mcnt != 0 && mdir == hi) ? mcnt + 1 : 1;
      mdir = hi;
      if (c1 == SAT) begin
        mcnt = 0;
        if (hi && mc < 127) begin mc++; ni = 128; nf = 128; end
        else if (!hi && mc > 0) begin mc--; ni = 128; nf = 128; end
      end else mcnt = c1;
    end
    mi = ni; mf = nf;
  endtask

  task automatic cyc(bit t, bit l, bit lk, string r);
    tick = t; late = l; lock = lk;
    @(posedge clk);
    model(t, l, lk);
    @(negedge clk);
    chk_all(r);
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1");
    // R2: no strobe, phase bit toggling
    for (int i = 0; i < 40; i++) cyc(1'b0, i[0], 1'b0, "R2");
    // R3/R4: alternating phase around mid-scale, locked
    for (int i = 0; i < 60; i++) cyc(1'b1, i[0], 1'b1, "R4");
    // R3/R4/R5: pseudo-random phase and strobes, locked
    for (int i = 0; i < 3000; i++) begin
      step_lfsr();
      cyc(lfsr[0] | lfsr[3], lfsr[1], 1'b1, "R3");
    end
    // R8: pin high while locked, coarse must hold
    for (int i = 0; i < 400; i++) cyc(1'b1, 1'b1, 1'b1, "R8");
    chk("R8 coarse frozen", int'(coarse), CINIT);
    // R6: interrupted runs (one early strobe every SAT-1 lates) must not step
    for (int i = 0; i < 200; i++) cyc(1'b1, (i % SAT) != SAT - 1, 1'b0, "R6");
    chk("R6 interrupted run", int'(coarse), CINIT);
    // R6/R7: sustained late drives coarse to the top limit
    for (int i = 0; i < 12000; i++) cyc(1'b1, 1'b1, 1'b0, "R6");
    chk("R7 upper clamp", int'(coarse), 127);
    // R6/R7: sustained early drives coarse to the bottom limit
    for (int i = 0; i < 24000; i++) cyc(1'b1, 1'b0, 1'b0, "R6");
    chk("R7 lower clamp", int'(coarse), 0);
    // mixed acquisition with random lock
    for (int i = 0; i < 6000; i++) begin
      step_lfsr();
      cyc(lfsr[0] | lfsr[2] | lfsr[5], lfsr[1] | lfsr[4], lfsr[7] & lfsr[9], "R6");
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule